// File: doc/BRIEF.md
# Wait State Handover Generator

This block stalls a CPU bus cycle when it writes to a slow peripheral that owns an active-low WAIT output of its own. When the write select goes active, the block pulls the CPU ready line low at once and keeps it there for one local wait state. That wait state lasts a fixed number of clock cycles. After it, the block lets go of ready, and from then on only the peripheral's WAIT pin decides how much longer the CPU waits.

The peripheral asserts WAIT no later than a known window after the write select. The local wait state is sized to cover that window plus the latency of the synchroniser that brings WAIT into the clock domain. Because of this, the two stall sources overlap and ready never shows a one-cycle release between them. The sizing is checked at elaboration time. Address decoding and the peripheral's own timing lie outside this block.

Top module: `wait_handover_gen`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), with `cs_wr_n` and `periph_wait_n` high, `cpu_rdy` is high.
- R2: In the cycle in which `cs_wr_n` goes from high to low, `cpu_rdy` goes low. It stays low for exactly `HOLD_CYCLES` cycles (default 9) while the select is held and WAIT is high.
- R3: Once the local hold has run out, `cpu_rdy` returns high if the synchronised WAIT is high.
- R4: `periph_wait_n` passes through a two-stage synchroniser. A level driven on it in cycle c appears (inverted as a stall) at `cpu_rdy` in cycle c+2, and it follows WAIT whether or not a hold is running.
- R5: `cpu_rdy` is low exactly when the local hold OR the synchronised WAIT is active. If WAIT goes low within the window, there is no high cycle between the local hold and the peripheral's stall.
- R6: Only the high-to-low transition of `cs_wr_n` starts a hold. A select held low for any length of time yields one local wait state.
- R7: Driving `cs_wr_n` high ends the local hold in that same cycle and re-arms the generator, so the next falling edge starts a fresh full hold.
- R8: `HOLD_CYCLES` times the clock period must be at least the WAIT window (rounded up to whole cycles) plus the synchroniser depth in cycles. A smaller value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_wr_n | input | 1 | Write chip select of the peripheral, active low, synchronous to clk |
| periph_wait_n | input | 1 | Peripheral WAIT pin, active low, asynchronous |
| cpu_rdy | output | 1 | CPU ready, low inserts a wait state |

## Verification
A hold counter stuck at a wrong value shows at `cpu_rdy` by the end of the first access: ready either rises before the ninth cycle or stays low past it. A missed or repeated edge detection shows the same way. With a select held long, a spurious second stall appears within one hold length. A synchroniser with the wrong depth shifts the start and end of the peripheral stall by a cycle. That shift either opens a one-cycle gap after the local hold or moves the release, and the per-cycle comparison against the expected stall window catches it within the access.

// File: rtl/wh_pkg.sv
// Package: shared helpers for the wait state handover generator.
// Assumes all times are given in picoseconds as integers.
package wh_pkg;

    // Smallest local hold, in cycles, that covers the WAIT window plus the synchroniser.
    function automatic int unsigned min_hold_cycles(input int unsigned window_ps,
                                                    input int unsigned period_ps,
                                                    input int unsigned sync_stages);
        return (window_ps + period_ps - 1) / period_ps + sync_stages;
    endfunction

endpackage

// File: rtl/wh_sync.sv
// wh_sync: multi-stage synchroniser for an active-low asynchronous level.
// Assumes STAGES >= 2; resets to the inactive (high) level.
module wh_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stg;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '1;
        else        stg <= {stg[STAGES-2:0], din};
    end

    assign dout = stg[STAGES-1];

    // Each stage must carry the previous stage's value one cycle later (R4).
    for (genvar i = 1; i < STAGES; i++) begin : g_chk
        assert_sync_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> stg[i] == $past(stg[i-1]));
    end
endmodule

// File: rtl/wh_edge.sv
// wh_edge: finds the start of a write access (select going active).
// Assumes the select is synchronous to clk.
module wh_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    output logic sel_q,
    output logic start
);
    // Remember the select level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= sel;
    end

    assign start = sel & ~sel_q;

    // A start never occurs in two consecutive cycles (R6).
    assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
endmodule

// File: rtl/wh_hold.sv
// wh_hold: local wait state timer. Starts on 'start', lasts HOLD_CYCLES
// cycles including the start cycle, and drops as soon as the select goes away.
// Assumes HOLD_CYCLES >= 2.
module wh_hold #(
    parameter int unsigned HOLD_CYCLES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sel,
    output logic hold
);
    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Load on start, count down to zero, clear when the select is released.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (!sel)           cnt <= '0;
        else if (start)          cnt <= RELOAD;
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign hold = sel & (start | (cnt != '0));

    // Counter never exceeds the reload value (R2).
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= RELOAD);
    // An expired hold does not restart while the select stays active (R6).
    assert_no_retrigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && sel && !start) |=> (cnt == '0 || !sel || start));
    // Releasing the select clears the hold state (R7).
    assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> cnt == '0);
    // A start loads the full hold (R2).
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && sel) |=> (cnt == RELOAD || !sel));
endmodule

// File: rtl/wait_handover_gen.sv
// wait_handover_gen: inserts one local wait state on each peripheral write,
// then leaves the CPU ready line to the peripheral's synchronised WAIT pin.
// Assumes cs_wr_n is synchronous to clk and periph_wait_n is asynchronous.
module wait_handover_gen #(
    parameter int unsigned CLK_PERIOD_PS  = 20000,
    parameter int unsigned WAIT_WINDOW_PS = 130000,
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned HOLD_CYCLES    = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_wr_n,
    input  logic periph_wait_n,
    output logic cpu_rdy
);
    import wh_pkg::*;

    localparam int unsigned MIN_HOLD =
        min_hold_cycles(WAIT_WINDOW_PS, CLK_PERIOD_PS, SYNC_STAGES);

    // Elaboration-time sizing check of the local hold (R8).
    if (HOLD_CYCLES < MIN_HOLD) begin : g_bad_hold_R8
        $error("HOLD_CYCLES too small to cover WAIT window and synchroniser");
    end

    logic sel, sel_q, start, hold, wait_sync_n, wait_stall;

    assign sel = ~cs_wr_n;

    wh_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .sel_q (sel_q),
        .start (start)
    );

    wh_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .sel   (sel),
        .hold  (hold)
    );

    wh_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (periph_wait_n),
        .dout  (wait_sync_n)
    );

    assign wait_stall = ~wait_sync_n;
    assign cpu_rdy    = ~(hold | wait_stall);

    // A new access stalls the CPU in its first cycle (R2).
    assert_stall_on_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !sel_q) |-> !cpu_rdy);
    // A synchronised WAIT always stalls the CPU (R5).
    assert_wait_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_sync_n |-> !cpu_rdy);
    // With select released and WAIT idle, the CPU is never stalled (R7).
    assert_idle_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && wait_sync_n) |-> cpu_rdy);
endmodule

// File: tb/tb_wait_handover_gen.sv
module tb_wait_handover_gen;
    localparam int CLK_PERIOD = 20;
    localparam int HOLD = 9;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_wr_n = 1'b1;
    logic periph_wait_n = 1'b1;
    logic cpu_rdy;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wait_handover_gen #(
        .CLK_PERIOD_PS(CLK_PERIOD*1000),
        .WAIT_WINDOW_PS(130000),
        .SYNC_STAGES(SYNC),
        .HOLD_CYCLES(HOLD)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cs_wr_n(cs_wr_n),
        .periph_wait_n(periph_wait_n), .cpu_rdy(cpu_rdy)
    );

    task automatic check(input string req, input logic act, input logic exp, input int cyc);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cycle %0d: cpu_rdy=%b expected %b", req, cyc, act, exp);
        end
    endtask

    // R1: reset state.
    task automatic t_reset();
        @(negedge clk); rst_n = 1'b0; cs_wr_n = 1'b1; periph_wait_n = 1'b1;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1", cpu_rdy, 1'b1, 0);
    endtask

    // One access: select low for sel_len cycles, WAIT low from cycle d for l cycles.
    // Expected stall: local hold while c < sel_len and c < HOLD (R2, R3, R6, R7),
    // OR the WAIT level delayed by SYNC cycles (R4, R5).
    task automatic t_access(input string req, input int sel_len, input int d,
                            input int l, input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            cs_wr_n = (c < sel_len) ? 1'b0 : 1'b1;
            periph_wait_n = (c >= d && c < d + l) ? 1'b0 : 1'b1;
            #1;
            check(req, cpu_rdy,
                  !(((c < sel_len) && (c < HOLD)) || (c >= d + SYNC && c < d + l + SYNC)), c);
        end
        @(negedge clk); cs_wr_n = 1'b1; periph_wait_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_access("R2_R3 hold only", 12, 0, 0, 14);
        t_access("R5 short wait inside hold", 12, 0, 1, 14);
        t_access("R5 no gap long wait", 30, 7, 20, 34);
        t_access("R5 no gap wait ends just after hold", 16, 7, 3, 16);
        t_access("R6 held select one hold", 40, 0, 0, 42);
        t_access("R7 early release", 3, 0, 0, 10);
        t_access("R7 re-armed full hold", 12, 0, 0, 14);
        t_access("R4 wait without select", 0, 1, 4, 10);
        t_access("R4 wait late after hold", 20, 12, 2, 18);
        t_reset();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule